// File: doc/BRIEF.md
# GPIO Port with Level Alarms

This block is one general-purpose I/O port of parameterizable width. A host sends single commands. Each command is an operation code plus one argument word. Most commands treat the argument as a bit mask. The operations are:

- set or clear output bits;
- turn pins into inputs or outputs;
- arm or disarm level alarms;
- read the sampled input pins;
- read the output shadow register.

Every accepted command produces exactly one response word.

On the pin side, the output vector always mirrors the output shadow register, and the output-enable vector mirrors the direction register. Input pins pass through a two-stage synchronizer before they are read or compared. A single `alarm_pending` flag is high while any bit is in its armed state:

- a bit armed for high has its synchronized input at 1;
- a bit armed for low has its synchronized input at 0.

Software can poll or wait on this flag.

The command side is valid/ready and the response side is valid/ready.

- A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- The response slot holds one word. `cmd_ready` is high when the slot is empty or is being drained in the same cycle.
- When `rsp_ready` is held low, the response stays valid and unchanged, and further commands are stalled.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, no alarm is armed (`alarm_pending` 0), `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: Op 0x2 (set) forces to 1 each shadow bit whose argument bit is 1, leaves all other bits alone, and responds with the new shadow; `pin_out` shows the shadow from the edge that accepts the command.
- R3: Op 0x3 (clear) forces to 0 each shadow bit whose argument bit is 1, leaves all other bits alone, and responds with the new shadow.
- R4: Op 0x7 (make input) turns each masked bit into an input, leaves other directions alone, and responds with the mask of bits that are now inputs (the complement of `pin_oe`).
- R5: Op 0x8 (make output) turns each masked bit into an output, leaves other directions alone, and responds with the mask of bits that are now outputs.
- R6: Op 0x0 responds with the synchronized input pins and op 0x1 responds with the output shadow; a change on `pin_in` reaches the synchronized value, and `alarm_pending`, on the second rising edge after it.
- R7: Op 0x4 arms a high alarm on each masked bit and responds with the full high-armed mask; `alarm_pending` is 1 while any high-armed bit has synchronized input 1.
- R8: Op 0x5 arms a low alarm on each masked bit and responds with the full low-armed mask; `alarm_pending` is 1 while any low-armed bit has synchronized input 0.
- R9: Op 0x6 disarms both alarm kinds on the masked bits only and responds with the OR of the remaining high and low armed masks.
- R10: `cmd_ready` equals (not `rsp_valid`) or `rsp_ready`; while `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds steady and no command changes state.
- R11: Ops 0x9 to 0xF change no state and respond with 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_arg | input | WIDTH | Mask or data argument |
| rsp_valid | output | 1 | Response word held in slot |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | WIDTH | Response word |
| pin_in | input | WIDTH | Raw input pins |
| pin_out | output | WIDTH | Output shadow driven to pins |
| pin_oe | output | WIDTH | Per-bit output enable (1 = output) |
| alarm_pending | output | 1 | Some armed bit is at its armed level |

## Verification
Timing of results after a command is accepted on edge k:

- Register effects are visible from edge k onward. This covers `pin_out`, `pin_oe`, the arm masks behind `alarm_pending`, and the response word with `rsp_valid`.
- The bench issues each command just after a falling edge and lowers `cmd_valid` right after the accepting edge.
- It then samples response, pins and alarm flag at the following falling edge.

Timing of a pin change:

- A pin change needs two rising edges to take effect.
- After one edge the bench confirms the alarm still reflects the old pins.
- After the second edge it compares against its model.

For back-pressure, the bench holds `rsp_ready` low and checks across a stalled edge that the response does not move and that the blocked command leaves no trace on the pins.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;
  localparam int OP_W = 4;
  typedef enum logic [OP_W-1:0] {
    OP_RD_IN   = 4'h0,
    OP_RD_OUT  = 4'h1,
    OP_SET     = 4'h2,
    OP_CLR     = 4'h3,
    OP_ARM_HI  = 4'h4,
    OP_ARM_LO  = 4'h5,
    OP_DISARM  = 4'h6,
    OP_MK_IN   = 4'h7,
    OP_MK_OUT  = 4'h8
  } gpio_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] arg,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] shadow_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] arm_hi_q,
  output logic [WIDTH-1:0] arm_lo_q,
  output logic [WIDTH-1:0] rsp_word
);
  logic [WIDTH-1:0] shadow_d, dir_d, arm_hi_d, arm_lo_d;

  always_comb begin
    shadow_d = shadow_q;
    dir_d    = dir_q;
    arm_hi_d = arm_hi_q;
    arm_lo_d = arm_lo_q;
    rsp_word = '0;
    case (op)
      OP_RD_IN:  rsp_word = pin_sync;
      OP_RD_OUT: rsp_word = shadow_q;
      OP_SET: begin
        shadow_d = shadow_q | arg;
        rsp_word = shadow_d;
      end
      OP_CLR: begin
        shadow_d = shadow_q & ~arg;
        rsp_word = shadow_d;
      end
      OP_ARM_HI: begin
        arm_hi_d = arm_hi_q | arg;
        rsp_word = arm_hi_d;
      end
      OP_ARM_LO: begin
        arm_lo_d = arm_lo_q | arg;
        rsp_word = arm_lo_d;
      end
      OP_DISARM: begin
        arm_hi_d = arm_hi_q & ~arg;
        arm_lo_d = arm_lo_q & ~arg;
        rsp_word = arm_hi_d | arm_lo_d;
      end
      OP_MK_IN: begin
        dir_d    = dir_q & ~arg;
        rsp_word = ~dir_d;
      end
      OP_MK_OUT: begin
        dir_d    = dir_q | arg;
        rsp_word = dir_d;
      end
      default: rsp_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      dir_q    <= '0;
      arm_hi_q <= '0;
      arm_lo_q <= '0;
    end else if (fire) begin
      shadow_q <= shadow_d;
      dir_q    <= dir_d;
      arm_hi_q <= arm_hi_d;
      arm_lo_q <= arm_lo_d;
    end
  end
endmodule

// File: rtl/gpio_alarm_eval.sv
module gpio_alarm_eval #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] arm_hi,
  input  logic [WIDTH-1:0] arm_lo,
  output logic             pending
);
  logic [WIDTH-1:0] hit;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign hit[b] = (arm_hi[b] & pin_sync[b]) | (arm_lo[b] & ~pin_sync[b]);
  end

  assign pending = |hit;
endmodule

// File: rtl/gpio_rsp_slot.sv
module gpio_rsp_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
  import gpio_alarm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [WIDTH-1:0] cmd_arg,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             alarm_pending
);
  logic [WIDTH-1:0] pin_sync, arm_hi, arm_lo, rsp_word;
  logic             fire;

  assign fire = cmd_valid && cmd_ready;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(cmd_op), .arg(cmd_arg),
    .pin_sync(pin_sync), .shadow_q(pin_out), .dir_q(pin_oe),
    .arm_hi_q(arm_hi), .arm_lo_q(arm_lo), .rsp_word(rsp_word)
  );

  gpio_alarm_eval #(.WIDTH(WIDTH)) alarm_i (
    .pin_sync(pin_sync), .arm_hi(arm_hi), .arm_lo(arm_lo),
    .pending(alarm_pending)
  );

  gpio_rsp_slot #(.WIDTH(WIDTH)) slot_i (
    .clk(clk), .rst_n(rst_n), .load(fire), .load_data(rsp_word),
    .out_ready(rsp_ready), .out_valid(rsp_valid), .out_data(rsp_data),
    .can_load(cmd_ready)
  );
endmodule

// File: rtl/gpio_alarm_port_chk.sv
module gpio_alarm_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [3:0]       cmd_op,
  input logic [WIDTH-1:0] cmd_arg,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [WIDTH-1:0] rsp_data,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             alarm_pending
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !alarm_pending && !rsp_valid)); // R1
  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'h2 |=> (pin_out & $past(cmd_arg)) == $past(cmd_arg)); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'h2 |=> ((pin_out ^ $past(pin_out)) & ~$past(cmd_arg)) == '0); // R2
  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'h3 |=> (pin_out & $past(cmd_arg)) == '0); // R3
  AST_MK_IN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'h7 |=> (pin_oe & $past(cmd_arg)) == '0); // R4
  AST_MK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'h8 |=> (pin_oe & $past(cmd_arg)) == $past(cmd_arg)); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pin_out) && $stable(pin_oe)); // R10
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op > 4'h8 |=> $stable(pin_out) && $stable(pin_oe) && rsp_data == '0); // R11
endmodule

bind gpio_alarm_port gpio_alarm_port_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .alarm_pending(alarm_pending)
);

// File: tb/gpio_alarm_port_tb_top.sv
module gpio_alarm_port_tb_top;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [3:0]   cmd_op = '0;
  logic [W-1:0] cmd_arg = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_data;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         alarm_pending;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m_sh = '0, m_dir = '0, m_ah = '0, m_al = '0, m_pin = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alarm_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alarm_pending(alarm_pending)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic model_alarm();
    return |((m_ah & m_pin) | (m_al & ~m_pin));
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R6";
      4'h2: return "R2";
      4'h3: return "R3";
      4'h4: return "R7";
      4'h5: return "R8";
      4'h6: return "R9";
      4'h7: return "R4";
      4'h8: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W-1:0] model_step(logic [3:0] op, logic [W-1:0] a);
    case (op)
      4'h0: return m_pin;
      4'h1: return m_sh;
      4'h2: begin m_sh = m_sh | a; return m_sh; end
      4'h3: begin m_sh = m_sh & ~a; return m_sh; end
      4'h4: begin m_ah = m_ah | a; return m_ah; end
      4'h5: begin m_al = m_al | a; return m_al; end
      4'h6: begin m_ah = m_ah & ~a; m_al = m_al & ~a; return m_ah | m_al; end
      4'h7: begin m_dir = m_dir & ~a; return ~m_dir; end
      4'h8: begin m_dir = m_dir | a; return m_dir; end
      default: return '0;
    endcase
  endfunction

  task automatic exec(logic [3:0] op, logic [W-1:0] a);
    logic [W-1:0] exp;
    string req;
    req = req_of(op);
    @(negedge clk);
    cmd_op = op; cmd_arg = a; cmd_valid = 1'b1;
    exp = model_step(op, a);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_data", 32'(rsp_data), 32'(exp));
    check(req, "pin_out", 32'(pin_out), 32'(m_sh));
    check(req, "pin_oe", 32'(pin_oe), 32'(m_dir));
    check(req, "alarm_pending", 32'(alarm_pending), 32'(model_alarm()));
  endtask

  task automatic set_pins(logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(posedge clk);
    @(negedge clk);
    check("R6", "alarm after one edge", 32'(alarm_pending), 32'(model_alarm()));
    @(posedge clk);
    @(negedge clk);
    m_pin = v;
    check("R6", "alarm after two edges", 32'(alarm_pending), 32'(model_alarm()));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pin_oe", 32'(pin_oe), 32'd0);
    check("R1", "pin_out", 32'(pin_out), 32'd0);
    check("R1", "alarm_pending", 32'(alarm_pending), 32'd0);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cmd_ready", 32'(cmd_ready), 32'd1);

    exec(4'h2, 8'hA5);
    exec(4'h2, 8'h0F);
    exec(4'h3, 8'h30);
    exec(4'h8, 8'hF0);
    exec(4'h7, 8'h30);
    set_pins(8'h3C);
    exec(4'h0, 8'h00);
    exec(4'h1, 8'h00);
    exec(4'h4, 8'h04);
    exec(4'h6, 8'h04);
    exec(4'h5, 8'h01);
    exec(4'h4, 8'h80);
    exec(4'h6, 8'h01);
    set_pins(8'h80);
    exec(4'h5, 8'h02);
    exec(4'h6, 8'hFF);
    exec(4'hC, 8'hFF);
    exec(4'hF, 8'h5A);

    // R10: response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    exec(4'h3, 8'hFF);
    held = rsp_data;
    @(negedge clk);
    cmd_op = 4'h2; cmd_arg = 8'h02; cmd_valid = 1'b1;
    #1 check("R10", "cmd_ready while stalled", 32'(cmd_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R10", "rsp_valid held", 32'(rsp_valid), 32'd1);
    check("R10", "rsp_data held", 32'(rsp_data), 32'(held));
    check("R10", "blocked cmd no effect", 32'(pin_out), 32'(m_sh));
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", "slot drained", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) set_pins(W'($urandom));
      exec(4'($urandom % 16), W'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule